// File: doc/BRIEF.md
# I2C Master Bit-Level Line Timer

This block produces the clock and data line waveforms of an I2C master one bus event at a time. Software programs a high count, a low count and a spike-filter length. A controller above the block then issues a start request, a series of bit requests that each carry one data value, and a stop request. Both lines are open-drain. The block drives each line through a drive-low enable: 1 pulls the line low and 0 lets it float high. The block reads both lines back through a spike-suppression filter.

Each phase is timed from its own reference point, and each reference adds a fixed number of cycles. The clock-high phase counts only once the filtered clock line reads high, so rise time and a target that stretches the clock are absorbed with no extra logic. The clock-low phase and the START hold count from the cycle in which the block drives the line, with no check of the input. The counts are raised to a floor set by the filter length. Only the per-phase counts set the bit rate, and nothing checks or limits it.

Top module: `i2c_scl_timer`

## Requirements
- R1: While reset is held and after it is released, scl_drive_low, sda_drive_low and op_done are 0.
- R2: In the idle state, with both filtered lines high, a start request drives SDA low while SCL stays released. SCL is driven low exactly HC+3 cycles later, where HC is the effective high count, and op_done pulses in the cycle SCL goes low.
- R3: A bit or stop request is accepted while SCL is parked low. SCL is then held low for exactly LC+1 cycles counted from the accepting edge, where LC is the effective low count, and is then released.
- R4: SDA changes one cycle after the accepting edge. For a bit, sda_drive_low becomes the inverse of bit_val, so a 1 releases the line. For a stop it becomes 1. SDA never changes while SCL is released, except at the end of a stop.
- R5: With a line that follows the drive at once, SCL stays released for HC+SPK+8 cycles, where SPK is the filter length. The count starts once the filtered SCL reads high.
- R6: op_done is a single-cycle pulse. It comes in the cycle SCL is driven low at the end of a START or a bit, and in the cycle SDA is released at the end of a stop.
- R7: A target that holds SCL low for D extra cycles after the release lengthens the released time by exactly D cycles.
- R8: At the end of a stop, SDA is released while SCL stays released, and the block returns to the idle state.
- R9: A start request is ignored while parked, or while filtered SDA or SCL is low. Bit and stop requests are ignored while idle. Both lines stay unchanged and op_done stays 0.
- R10: HC equals max(hi_count, SPK+5).
- R11: LC equals max(lo_count, SPK+7).
- R12: The filter ignores a line pulse that lasts SPK cycles or fewer, and it accepts a pulse that lasts SPK+1 cycles.
- R13: The count and filter-length inputs are taken only while idle or parked. A change during an operation does not affect that operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hi_count | input | CNT_W | Programmed high count |
| lo_count | input | CNT_W | Programmed low count |
| spike_len | input | SPK_W | Filter length in cycles |
| start_req | input | 1 | Start request |
| bit_req | input | 1 | Bit request |
| bit_val | input | 1 | Data value for a bit request |
| stop_req | input | 1 | Stop request, which wins over bit_req |
| scl_in | input | 1 | Clock line as read from the bus |
| sda_in | input | 1 | Data line as read from the bus |
| scl_drive_low | output | 1 | 1 pulls the clock line low |
| sda_drive_low | output | 1 | 1 pulls the data line low |
| op_done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with its default widths, CNT_W of 16 and SPK_W of 8. At run time it programs small counts, such as a high count of 20, a low count of 30 and a filter length of 2, so that every phase is counted cycle by cycle against the HC+3, LC+1 and HC+SPK+8 formulas. It then programs counts below their floors with a filter length of 3, which exercises the clamp on both counts. An open-drain line model with a target hold input lets the bench stretch the clock and inject pulses of SPK and SPK+1 cycles on the clock line.

// File: rtl/sclg_pkg.sv
package sclg_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HOLD,
    ST_PARK,
    ST_LOW,
    ST_HWAIT,
    ST_HIGH
  } sclg_state_e;

  // synchronizer depth in front of the spike filter
  localparam int unsigned SYNC_STAGES = 2;
  // START hold: compare end at HC+2 gives HC+3 cycles of SDA low before SCL falls
  localparam int unsigned HOLD_TAIL   = 2;
  // high phase: 1 counter + 4 filter path + 3 output latency on top of HC
  localparam int unsigned HIGH_TOTAL  = 8;
  localparam int unsigned HIGH_TAIL   = HIGH_TOTAL - (SYNC_STAGES + 3);
  // minimum effective counts above the filter length
  localparam int unsigned HCNT_FLOOR  = 5;
  localparam int unsigned LCNT_FLOOR  = 7;
endpackage

// File: rtl/sclg_glitch_filter.sv
module sclg_glitch_filter #(
  parameter int SPK_W    = 8,
  parameter int SYNC_LEN = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SPK_W-1:0] spk_len,
  input  logic             line_raw,
  output logic             line_filt
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [SYNC_LEN-1:0] sync_q;
  logic [SPK_W-1:0]    run_q;
  logic                filt_q;
  logic                synced;

  assign synced = sync_q[SYNC_LEN-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
      run_q  <= '0;
      filt_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_LEN-2:0], line_raw};
      if (synced == filt_q) begin
        run_q <= '0;
      end else if (run_q >= spk_len) begin
        filt_q <= synced;
        run_q  <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  assign line_filt = filt_q;
endmodule

// File: rtl/sclg_count_floor.sv
module sclg_count_floor #(
  parameter int CNT_W = 16,
  parameter int SPK_W = 8,
  parameter int FLOOR = 5
) (
  input  logic [CNT_W-1:0] raw_cnt,
  input  logic [SPK_W-1:0] spk_len,
  output logic [CNT_W:0]   eff_cnt
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int EW = CNT_W + 1;

  logic [EW-1:0] floor_v;
  logic [EW-1:0] raw_ext;

  assign floor_v = {{(EW-SPK_W){1'b0}}, spk_len} + EW'(FLOOR);
  assign raw_ext = {1'b0, raw_cnt};

  always_comb begin
    if (raw_ext < floor_v) eff_cnt = floor_v;
    else                   eff_cnt = raw_ext;
  end
endmodule

// File: rtl/i2c_scl_timer.sv
module i2c_scl_timer
  import sclg_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int SPK_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] hi_count,
  input  logic [CNT_W-1:0] lo_count,
  input  logic [SPK_W-1:0] spike_len,
  input  logic             start_req,
  input  logic             bit_req,
  input  logic             bit_val,
  input  logic             stop_req,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             scl_drive_low,
  output logic             sda_drive_low,
  output logic             op_done
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int LINES = 2;
  localparam int EW    = CNT_W + 1;
  localparam int CW    = CNT_W + 2;

  logic [LINES-1:0] raw_w;
  logic [LINES-1:0] filt_w;
  logic             scl_f;
  logic             sda_f;

  logic [EW-1:0]    h_eff, l_eff;
  logic [EW-1:0]    h_eff_q, l_eff_q;
  logic [SPK_W-1:0] spk_q;

  sclg_state_e      st_q;
  logic [CW-1:0]    cnt_q;
  logic [CW-1:0]    hold_end, high_end, low_end;
  logic             scl_dl_q, sda_dl_q, done_q;
  logic             stop_q, bit_q;
  logic             at_rest;

  assign raw_w = {sda_in, scl_in};

  for (genvar g = 0; g < LINES; g++) begin : g_filt
    sclg_glitch_filter #(
      .SPK_W   (SPK_W),
      .SYNC_LEN(SYNC_STAGES)
    ) u_filt (
      .clk      (clk),
      .rst      (rst),
      .spk_len  (spk_q),
      .line_raw (raw_w[g]),
      .line_filt(filt_w[g])
    );
  end

  assign scl_f = filt_w[0];
  assign sda_f = filt_w[1];

  sclg_count_floor #(.CNT_W(CNT_W), .SPK_W(SPK_W), .FLOOR(HCNT_FLOOR)) u_hfloor (
    .raw_cnt(hi_count), .spk_len(spike_len), .eff_cnt(h_eff)
  );

  sclg_count_floor #(.CNT_W(CNT_W), .SPK_W(SPK_W), .FLOOR(LCNT_FLOOR)) u_lfloor (
    .raw_cnt(lo_count), .spk_len(spike_len), .eff_cnt(l_eff)
  );

  assign hold_end = {1'b0, h_eff_q} + CW'(HOLD_TAIL);
  assign high_end = {1'b0, h_eff_q} + CW'(HIGH_TAIL);
  assign low_end  = {1'b0, l_eff_q};
  assign at_rest  = (st_q == ST_IDLE) || (st_q == ST_PARK);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      cnt_q    <= '0;
      scl_dl_q <= 1'b0;
      sda_dl_q <= 1'b0;
      done_q   <= 1'b0;
      stop_q   <= 1'b0;
      bit_q    <= 1'b0;
      h_eff_q  <= EW'(HCNT_FLOOR);
      l_eff_q  <= EW'(LCNT_FLOOR);
      spk_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (at_rest) begin
        h_eff_q <= h_eff;
        l_eff_q <= l_eff;
        spk_q   <= spike_len;
      end
      case (st_q)
        ST_IDLE: begin
          if (start_req && scl_f && sda_f) begin
            sda_dl_q <= 1'b1;
            cnt_q    <= '0;
            st_q     <= ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (cnt_q == hold_end) begin
            scl_dl_q <= 1'b1;
            done_q   <= 1'b1;
            st_q     <= ST_PARK;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        ST_PARK: begin
          if (stop_req) begin
            stop_q <= 1'b1;
            cnt_q  <= '0;
            st_q   <= ST_LOW;
          end else if (bit_req) begin
            stop_q <= 1'b0;
            bit_q  <= bit_val;
            cnt_q  <= '0;
            st_q   <= ST_LOW;
          end
        end
        ST_LOW: begin
          if (cnt_q == '0) sda_dl_q <= stop_q | ~bit_q;
          if (cnt_q == low_end) begin
            scl_dl_q <= 1'b0;
            st_q     <= ST_HWAIT;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        ST_HWAIT: begin
          if (scl_f) begin
            cnt_q <= '0;
            st_q  <= ST_HIGH;
          end
        end
        ST_HIGH: begin
          if (cnt_q == high_end) begin
            done_q <= 1'b1;
            if (stop_q) begin
              sda_dl_q <= 1'b0;
              st_q     <= ST_IDLE;
            end else begin
              scl_dl_q <= 1'b1;
              st_q     <= ST_PARK;
            end
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign scl_drive_low = scl_dl_q;
  assign sda_drive_low = sda_dl_q;
  assign op_done       = done_q;
endmodule

// File: rtl/sclg_checker.sv
module sclg_checker
  import sclg_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int SPK_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             scl_dl,
  input logic             sda_dl,
  input logic             done,
  input logic [CNT_W:0]   h_eff,
  input logic [CNT_W:0]   l_eff,
  input logic [SPK_W-1:0] spk
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int EW = CNT_W + 1;

  logic [31:0] low_run;

  always_ff @(posedge clk) begin
    if (rst) low_run <= '0;
    else if (scl_dl) low_run <= (low_run == 32'hFFFF_FFFF) ? low_run : low_run + 32'd1;
    else low_run <= '0;
  end

  assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_edge_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> ($rose(scl_dl) || $fell(sda_dl)));

  assert_sda_release_R8: assert property (@(posedge clk) disable iff (rst)
    ($fell(sda_dl) && !scl_dl) |-> done);

  assert_low_length_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(scl_dl) |-> (low_run >= (32'(l_eff) + 32'd1)));

  assert_start_hold_R2: assert property (@(posedge clk) disable iff (rst)
    ($rose(sda_dl) && !scl_dl) |=> (sda_dl && !scl_dl));

  assert_hfloor_R10: assert property (@(posedge clk) disable iff (rst)
    h_eff >= (EW'(spk) + EW'(HCNT_FLOOR)));

  assert_lfloor_R11: assert property (@(posedge clk) disable iff (rst)
    l_eff >= (EW'(spk) + EW'(LCNT_FLOOR)));
endmodule

bind i2c_scl_timer sclg_checker #(.CNT_W(CNT_W), .SPK_W(SPK_W)) u_sclg_chk (
  .clk   (clk),
  .rst   (rst),
  .scl_dl(scl_drive_low),
  .sda_dl(sda_drive_low),
  .done  (op_done),
  .h_eff (h_eff_q),
  .l_eff (l_eff_q),
  .spk   (spk_q)
);

// File: tb/i2c_scl_timer_bench.sv
module i2c_scl_timer_bench;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int CNT_W = 16;
  localparam int SPK_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [CNT_W-1:0] hi_count = 16'd20;
  logic [CNT_W-1:0] lo_count = 16'd30;
  logic [SPK_W-1:0] spike_len = 8'd2;
  logic start_req = 1'b0, bit_req = 1'b0, bit_val = 1'b0, stop_req = 1'b0;
  logic tgt_hold = 1'b0, sda_hold = 1'b0;
  logic scl_in, sda_in;
  logic scl_drive_low, sda_drive_low, op_done;

  int n_chk = 0;
  int n_fail = 0;

  int   w_low, w_high;
  logic w_s1, w_s2, w_tog, w_hsda, w_escl, w_esda, w_dnext, w_ok;

  always #2.5 clk = ~clk;

  assign scl_in = ~(scl_drive_low | tgt_hold);
  assign sda_in = ~(sda_drive_low | sda_hold);

  i2c_scl_timer #(.CNT_W(CNT_W), .SPK_W(SPK_W)) u_i2c_scl_timer (
    .clk(clk), .rst(rst), .hi_count(hi_count), .lo_count(lo_count),
    .spike_len(spike_len), .start_req(start_req), .bit_req(bit_req),
    .bit_val(bit_val), .stop_req(stop_req), .scl_in(scl_in), .sda_in(sda_in),
    .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low), .op_done(op_done)
  );

  task automatic chk_eq(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic issue(input logic is_stop, input logic v);
    @(negedge clk);
    if (is_stop) stop_req = 1'b1;
    else begin bit_req = 1'b1; bit_val = v; end
    @(negedge clk);
    stop_req = 1'b0;
    bit_req  = 1'b0;
  endtask

  // samples once per cycle at the falling edge until op_done
  task automatic watch();
    w_ok = 1'b0; w_low = 0; w_high = 0; w_tog = 1'b0;
    w_s1 = sda_drive_low; w_s2 = 1'b0; w_hsda = 1'b0;
    for (int k = 0; k < 8000; k++) begin
      if (k > 0) @(negedge clk);
      if (k == 1) w_s2 = sda_drive_low;
      if (op_done) begin
        w_escl = scl_drive_low; w_esda = sda_drive_low; w_ok = 1'b1;
        break;
      end
      if (scl_drive_low) begin
        if (w_high == 0) w_low++;
      end else begin
        if (w_high == 0) w_hsda = sda_drive_low;
        else if (sda_drive_low != w_hsda) w_tog = 1'b1;
        w_high++;
      end
    end
    @(negedge clk);
    w_dnext = op_done;
  endtask

  task automatic t_start(input int exp_hold);
    int n = 0;
    logic ok = 1'b0, e_scl = 1'b0, e_sda = 1'b0;
    @(negedge clk); start_req = 1'b1;
    @(negedge clk); start_req = 1'b0;
    for (int k = 0; k < 8000; k++) begin
      if (k > 0) @(negedge clk);
      if (op_done) begin ok = 1'b1; e_scl = scl_drive_low; e_sda = sda_drive_low; break; end
      if (sda_drive_low && !scl_drive_low) n++;
    end
    chk_eq("R2 start done seen", int'(ok), 1);
    chk_eq("R2 start hold cycles", n, exp_hold);
    chk_eq("R6 scl low at start done", int'(e_scl), 1);
    chk_eq("R2 sda low at start done", int'(e_sda), 1);
    @(negedge clk);
    chk_eq("R6 start done one cycle", int'(op_done), 0);
  endtask

  task automatic t_bit(input logic v, input int el, input int eh);
    logic prev;
    prev = sda_drive_low;
    issue(1'b0, v);
    watch();
    chk_eq("R6 bit done seen", int'(w_ok), 1);
    chk_eq("R3 bit low cycles", w_low, el);
    chk_eq("R4 sda unchanged on accept cycle", int'(w_s1), int'(prev));
    chk_eq("R4 sda set one cycle later", int'(w_s2), int'(!v));
    chk_eq("R4 sda stable while scl released", int'(w_tog), 0);
    chk_eq("R5 bit high cycles", w_high, eh);
    chk_eq("R6 scl driven low at bit done", int'(w_escl), 1);
    chk_eq("R6 bit done one cycle", int'(w_dnext), 0);
  endtask

  task automatic t_stop(input int el, input int eh);
    issue(1'b1, 1'b0);
    watch();
    chk_eq("R8 stop done seen", int'(w_ok), 1);
    chk_eq("R3 stop low cycles", w_low, el);
    chk_eq("R4 stop drives sda low", int'(w_s2), 1);
    chk_eq("R5 stop high cycles", w_high, eh);
    chk_eq("R8 scl released at stop done", int'(w_escl), 0);
    chk_eq("R8 sda released at stop done", int'(w_esda), 0);
    chk_eq("R6 stop done one cycle", int'(w_dnext), 0);
  endtask

  task automatic t_stretch(input int x, input int eh);
    tgt_hold = 1'b1;
    issue(1'b0, 1'b1);
    fork
      watch();
      begin
        while (scl_drive_low) @(negedge clk);
        repeat (x) @(negedge clk);
        tgt_hold = 1'b0;
      end
    join
    chk_eq("R7 stretched high cycles", w_high, eh);
  endtask

  task automatic t_spike(input int a, input int p, input int x, input int eh, input string req);
    tgt_hold = 1'b1;
    issue(1'b0, 1'b1);
    fork
      watch();
      begin
        while (scl_drive_low) @(negedge clk);
        repeat (a) @(negedge clk);
        tgt_hold = 1'b0;
        repeat (p) @(negedge clk);
        tgt_hold = 1'b1;
        repeat (x - a - p) @(negedge clk);
        tgt_hold = 1'b0;
      end
    join
    chk_eq(req, w_high, eh);
  endtask

  task automatic quiet(input int n, input logic es, input logic ed, input string req);
    int bad = 0;
    repeat (n) begin
      @(negedge clk);
      if (scl_drive_low != es || sda_drive_low != ed || op_done) bad++;
    end
    chk_eq(req, bad, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk_eq("R1 scl in reset", int'(scl_drive_low), 0);
    rst = 1'b0;
    @(negedge clk);
    chk_eq("R1 scl after reset", int'(scl_drive_low), 0);
    chk_eq("R1 sda after reset", int'(sda_drive_low), 0);
    chk_eq("R1 done after reset", int'(op_done), 0);
    repeat (8) @(negedge clk);

    // HC=20, LC=30, SPK=2: hold 23, low 31, high 30
    t_start(23);
    t_bit(1'b1, 31, 30);
    t_bit(1'b0, 31, 30);
    t_stretch(12, 42);
    t_spike(4, 2, 12, 42, "R12 pulse of SPK cycles ignored");
    t_spike(4, 3, 12, 34, "R12 pulse of SPK+1 cycles accepted");
    t_stop(31, 30);
    quiet(20, 1'b0, 1'b0, "R8 idle after stop");

    // R9: requests in the wrong state
    @(negedge clk); bit_req = 1'b1; stop_req = 1'b1;
    @(negedge clk); bit_req = 1'b0; stop_req = 1'b0;
    quiet(40, 1'b0, 1'b0, "R9 bit and stop ignored while idle");
    sda_hold = 1'b1;
    repeat (10) @(negedge clk);
    @(negedge clk); start_req = 1'b1;
    @(negedge clk); start_req = 1'b0;
    quiet(40, 1'b0, 1'b0, "R9 start ignored while sda low");
    sda_hold = 1'b0;
    repeat (10) @(negedge clk);
    t_start(23);
    @(negedge clk); start_req = 1'b1;
    @(negedge clk); start_req = 1'b0;
    quiet(40, 1'b1, 1'b1, "R9 start ignored while parked");

    // R13: counts change during a bit
    issue(1'b0, 1'b1);
    hi_count = 16'd40;
    lo_count = 16'd50;
    watch();
    chk_eq("R13 low unaffected by mid-op change", w_low, 31);
    chk_eq("R13 high unaffected by mid-op change", w_high, 30);
    t_bit(1'b0, 51, 50);
    t_stop(51, 50);
    repeat (10) @(negedge clk);

    // R10/R11: below the floors, SPK=3 -> HC=8, LC=10
    hi_count  = 16'd1;
    lo_count  = 16'd2;
    spike_len = 8'd3;
    repeat (10) @(negedge clk);
    t_start(11);
    t_bit(1'b1, 11, 19);
    chk_eq("R10 clamped high gives 19 cycles", w_high, 19);
    chk_eq("R11 clamped low gives 11 cycles", w_low, 11);
    t_stop(11, 19);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #750000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog R1-run expired actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule